// File: doc/BRIEF.md
# SRAM PLL Power-Up Sequencer

This block brings up an external synchronous SRAM whose internal PLL is held off by an active-low enable pin. The pin is driven by the output `doff_n`. From reset, `doff_n` stays low until the system reports that power and the memory clocks are stable. An optional pre-release delay may follow. `doff_n` is then released high. The block keeps it high for a lock interval so that the memory PLL can settle, and finally raises `init_done`.

The lock interval comes from parameters in one of three ways:

- a fixed number of cycles, which suits devices that specify a cycle count;
- a fixed time in microseconds converted with the clock period in picoseconds, which suits devices that specify a time independent of frequency;
- the larger of these two values.

The pre-release delay is also given in microseconds. A value of zero removes it. A simulation option shortens it to 10 cycles.

The controller has four states: RESET_LOW, PRE_DELAY, LOCK_WAIT and DONE. Its transitions are:

- RESET_LOW goes to PRE_DELAY when `clk_stable` is seen high.
- PRE_DELAY goes to LOCK_WAIT when the pre-delay interval expires.
- LOCK_WAIT goes to DONE when the lock interval expires.
- PRE_DELAY and LOCK_WAIT both go back to RESET_LOW when `clk_stable` is seen low. This check takes priority over interval expiry.
- DONE stays in DONE until reset.

An interval of N cycles keeps its state for N cycles. An interval of zero keeps its state for exactly one cycle.

Top module: `sram_pll_seq`

## Requirements
- R1: While `rst_n` is low, and on leaving reset, `doff_n` and `init_done` are both 0.
- R2: While `clk_stable` is low and the sequence has not finished, `doff_n` stays 0. A low `clk_stable` sampled at an edge gives `doff_n` = 0 after that edge.
- R3: Let edge t0 be the first edge that samples `clk_stable` high. With SIM_SHORT=0 and PRE_DELAY_US>0, `doff_n` rises after edge t0+P, where P = PRE_DELAY_US*10^6 / CLK_PERIOD_PS.
- R4: With SIM_SHORT=1 and PRE_DELAY_US>0, P is 10 cycles, whatever the clock period.
- R5: With PRE_DELAY_US=0, `doff_n` rises after edge t0+1.
- R6: `init_done` rises L edges after `doff_n` rises. L depends on LOCK_MODE: mode 0 gives LOCK_CYCLES, mode 1 gives LOCK_US*10^6 / CLK_PERIOD_PS, and mode 2 gives the larger of the two.
- R7: A lock count of zero gives L = 1. The block does not wrap around or stall.
- R8: If `clk_stable` is sampled low in PRE_DELAY or LOCK_WAIT, `doff_n` is 0 after that edge. The next high sample of `clk_stable` then starts the full pre-delay and lock sequence again.
- R9: Once `init_done` is 1, it stays 1 and `doff_n` stays 1 until reset, even if `clk_stable` falls.
- R10: `init_done` is never 1 while `doff_n` is 0. `init_done` rises only on the cycle after one in which `doff_n` was already 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable | input | 1 | High when power and the memory clocks are stable |
| doff_n | output | 1 | Active-low PLL-off drive to the SRAM |
| init_done | output | 1 | Power-up sequence complete (sticky until reset) |

## Verification
The checker examines the following on every cycle:

- whether `doff_n` stays low while `clk_stable` is low before completion;
- whether `doff_n` falls only after a low `clk_stable` sample;
- whether `init_done` stays high once set and always implies `doff_n`;
- whether `init_done` is preceded by a released `doff_n`.

Only the bench's scenarios can show the exact lengths of the pre-delay and lock intervals. The bench runs three parameter sets: a shortened pre-delay with the larger-of-two lock mode, a skipped pre-delay with a zero cycle count, and a time-only lock with a pre-delay derived from time. It also drops `clk_stable` during the pre-delay, during the lock wait and after completion, and compares the resulting restart timing against the timing it computes.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    typedef enum logic [1:0] {
        ST_RESET_LOW = 2'd0,
        ST_PRE_DELAY = 2'd1,
        ST_LOCK_WAIT = 2'd2,
        ST_DONE      = 2'd3
    } seq_state_e;

    localparam int LOCK_BY_CYCLES = 0;
    localparam int LOCK_BY_TIME   = 1;
    localparam int LOCK_BY_MAX    = 2;

    // microseconds to whole clock cycles, period given in picoseconds
    function automatic longint us_to_cycles(input longint us, input longint period_ps);
        return (us * 64'd1000000) / period_ps;
    endfunction

endpackage

// File: rtl/seq_interval.sv
`timescale 1ns/1ps
// Counts cycles while run is high; expired is set once LAST cycles have elapsed
// in the current run (counted from zero). Clears whenever run is low.
module seq_interval #(
    parameter int     W    = 8,
    parameter longint LAST = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST_V);

endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
    import sram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_stable,
    input  logic pre_expired,
    input  logic lock_expired,
    output logic pre_run,
    output logic lock_run,
    output logic doff_n,
    output logic init_done
);
    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions; loss of clock stability outranks interval expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET_LOW: if (clk_stable)        state_d = ST_PRE_DELAY;
            ST_PRE_DELAY: if (!clk_stable)       state_d = ST_RESET_LOW;
                          else if (pre_expired)  state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (!clk_stable)       state_d = ST_RESET_LOW;
                          else if (lock_expired) state_d = ST_DONE;
            ST_DONE:                             state_d = ST_DONE;
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        pre_run   = 1'b0;
        lock_run  = 1'b0;
        doff_n    = 1'b0;
        init_done = 1'b0;
        unique case (state_q)
            ST_RESET_LOW: ;
            ST_PRE_DELAY: pre_run = 1'b1;
            ST_LOCK_WAIT: begin
                lock_run = 1'b1;
                doff_n   = 1'b1;
            end
            ST_DONE: begin
                doff_n    = 1'b1;
                init_done = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sram_pll_seq.sv
`timescale 1ns/1ps
module sram_pll_seq
    import sram_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int PRE_DELAY_US  = 200,
    parameter int SIM_SHORT     = 0,
    parameter int LOCK_MODE     = LOCK_BY_MAX,
    parameter int LOCK_CYCLES   = 2048,
    parameter int LOCK_US       = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_stable,
    output logic doff_n,
    output logic init_done
);
    localparam longint PRE_CYC =
        (PRE_DELAY_US == 0) ? 64'd0 :
        (SIM_SHORT != 0)    ? 64'd10 :
        us_to_cycles(longint'(PRE_DELAY_US), longint'(CLK_PERIOD_PS));

    localparam longint LOCK_TIME_CYC = us_to_cycles(longint'(LOCK_US), longint'(CLK_PERIOD_PS));
    localparam longint LOCK_FIX_CYC  = longint'(LOCK_CYCLES);

    localparam longint LOCK_CYC =
        (LOCK_MODE == LOCK_BY_CYCLES) ? LOCK_FIX_CYC :
        (LOCK_MODE == LOCK_BY_TIME)   ? LOCK_TIME_CYC :
        ((LOCK_FIX_CYC > LOCK_TIME_CYC) ? LOCK_FIX_CYC : LOCK_TIME_CYC);

    // a zero count still occupies its state for one cycle
    localparam longint PRE_LAST  = (PRE_CYC  > 0) ? PRE_CYC  - 1 : 0;
    localparam longint LOCK_LAST = (LOCK_CYC > 0) ? LOCK_CYC - 1 : 0;

    localparam longint MAX_CYC = (PRE_CYC > LOCK_CYC) ? PRE_CYC : LOCK_CYC;
    localparam int     CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic pre_run, lock_run, pre_expired, lock_expired;

    seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_stable   (clk_stable),
        .pre_expired  (pre_expired),
        .lock_expired (lock_expired),
        .pre_run      (pre_run),
        .lock_run     (lock_run),
        .doff_n       (doff_n),
        .init_done    (init_done)
    );

    seq_interval #(.W(CNT_W), .LAST(PRE_LAST)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pre_run),
        .expired (pre_expired)
    );

    seq_interval #(.W(CNT_W), .LAST(LOCK_LAST)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (lock_run),
        .expired (lock_expired)
    );

endmodule

// File: rtl/sram_pll_seq_chk.sv
`timescale 1ns/1ps
module sram_pll_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_stable,
    input logic doff_n,
    input logic init_done
);
    // R2
    doff_low_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_stable && !init_done) |=> !doff_n);

    // R8
    doff_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doff_n) |-> !$past(clk_stable));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && doff_n));

    // R10
    done_needs_doff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> doff_n);

    // R10
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(doff_n));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_outputs_chk: assert (!doff_n && !init_done);
        end
    end

endmodule

bind sram_pll_seq sram_pll_seq_chk u_chk (.*);

// File: tb/sram_pll_seq_tb.sv
`timescale 1ns/1ps
module sram_pll_seq_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       clk_stable = 1'b0;
    logic [2:0] doff;
    logic [2:0] done;

    // A: short pre-delay, larger-of-two lock (2048 vs 20us@5ns=4000)
    sram_pll_seq #(.CLK_PERIOD_PS(5000), .PRE_DELAY_US(200), .SIM_SHORT(1),
                   .LOCK_MODE(2), .LOCK_CYCLES(2048), .LOCK_US(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .doff_n(doff[0]), .init_done(done[0]));

    // B: no pre-delay, zero cycle-count lock
    sram_pll_seq #(.CLK_PERIOD_PS(5000), .PRE_DELAY_US(0), .SIM_SHORT(0),
                   .LOCK_MODE(0), .LOCK_CYCLES(0), .LOCK_US(20)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .doff_n(doff[1]), .init_done(done[1]));

    // C: time pre-delay 1us=200 cycles, time-only lock 2us=400 (cycle count ignored)
    sram_pll_seq #(.CLK_PERIOD_PS(5000), .PRE_DELAY_US(1), .SIM_SHORT(0),
                   .LOCK_MODE(1), .LOCK_CYCLES(2048), .LOCK_US(2)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .doff_n(doff[2]), .init_done(done[2]));

    localparam longint PA = 10,  LA = 4000;
    localparam longint PB = 1,   LB = 1;
    localparam longint PC = 200, LC = 400;

    localparam int K_DOFF_UP = 0, K_DOFF_DN = 1, K_DONE_UP = 2, K_DONE_DN = 3;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int     dut;
        int     kind;
        longint at;
        string  req;
    } ev_t;

    ev_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_ev(input int d, input int k, input longint at, input string req);
        ev_t e;
        e.dut = d; e.kind = k; e.at = at; e.req = req;
        expq.push_back(e);
    endtask

    // monitor side: pop the oldest expectation of this instance and compare
    task automatic match_ev(input int d, input int k);
        int idx = -1;
        for (int i = 0; i < expq.size(); i++) begin
            if (idx < 0 && expq[i].dut == d) idx = i;
        end
        if (idx < 0) begin
            check(1'b0, "R2,R9", $sformatf("unexpected change dut%0d kind", d), k, -1);
        end else begin
            check(expq[idx].kind == k, expq[idx].req,
                  $sformatf("event kind dut%0d", d), k, expq[idx].kind);
            check(expq[idx].at == cyc, expq[idx].req,
                  $sformatf("event edge dut%0d kind%0d", d, k), cyc, expq[idx].at);
            expq.delete(idx);
        end
    endtask

    logic [2:0] prev_doff = '0;
    logic [2:0] prev_done = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 3; d++) begin
                if (doff[d] != prev_doff[d]) match_ev(d, doff[d] ? K_DOFF_UP : K_DOFF_DN);
                if (done[d] != prev_done[d]) match_ev(d, done[d] ? K_DONE_UP : K_DONE_DN);
            end
        end
        prev_doff <= doff;
        prev_done <= done;
    end

    // wait until the negedge just before edge e
    task automatic wait_edge(input longint e);
        @(negedge clk);
        while (cyc < e - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        longint t0;
        longint t1;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(doff == 3'b000, "R1", "doff_n in reset", doff, 0);
        check(done == 3'b000, "R1", "init_done in reset", done, 0);
        rst_n = 1'b1;

        // R2: clocks not stable, nothing moves
        repeat (20) @(negedge clk);
        check(doff == 3'b000, "R2", "doff_n while unstable", doff, 0);

        // full sequence on all three
        t0 = cyc + 3;
        push_ev(0, K_DOFF_UP, t0 + PA,      "R4");
        push_ev(0, K_DONE_UP, t0 + PA + LA, "R6");
        push_ev(1, K_DOFF_UP, t0 + PB,      "R5");
        push_ev(1, K_DONE_UP, t0 + PB + LB, "R7");
        push_ev(2, K_DOFF_UP, t0 + PC,      "R3");
        push_ev(2, K_DONE_UP, t0 + PC + LC, "R6");
        wait_edge(t0);
        clk_stable = 1'b1;
        wait_edge(t0 + PA + LA + 20);
        check(expq.size() == 0, "R6", "pending events", expq.size(), 0);
        check(done == 3'b111, "R10", "init_done all", done, 7);
        check(doff == 3'b111, "R10", "doff_n all", doff, 7);

        // R9: loss of clocks after completion is ignored
        clk_stable = 1'b0;
        repeat (50) @(negedge clk);
        check(done == 3'b111, "R9", "init_done after drop", done, 7);
        check(doff == 3'b111, "R9", "doff_n after drop", doff, 7);

        // R1: reset clears a finished sequence
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(doff == 3'b000 && done == 3'b000, "R1", "outputs after reset",
              {doff, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8: drop during lock (A) and pre-delay (C); B already done
        t0 = cyc + 3;
        push_ev(0, K_DOFF_UP, t0 + PA,      "R4");
        push_ev(1, K_DOFF_UP, t0 + PB,      "R5");
        push_ev(1, K_DONE_UP, t0 + PB + LB, "R7");
        push_ev(0, K_DOFF_DN, t0 + 100,     "R8");
        wait_edge(t0);
        clk_stable = 1'b1;
        wait_edge(t0 + 100);
        clk_stable = 1'b0;
        repeat (20) @(negedge clk);
        check(doff == 3'b010, "R8", "doff_n after mid drop", doff, 2);
        check(done == 3'b010, "R9", "init_done after mid drop", done, 2);

        // R8: restart runs the full sequence again
        t1 = cyc + 3;
        push_ev(0, K_DOFF_UP, t1 + PA,      "R8");
        push_ev(2, K_DOFF_UP, t1 + PC,      "R8");
        push_ev(2, K_DONE_UP, t1 + PC + LC, "R8");
        push_ev(0, K_DONE_UP, t1 + PA + LA, "R8");
        wait_edge(t1);
        clk_stable = 1'b1;
        wait_edge(t1 + PA + LA + 20);
        check(expq.size() == 0, "R8", "pending events after restart", expq.size(), 0);
        check(done == 3'b111, "R10", "init_done after restart", done, 7);

        finish_run();
    end

endmodule